// File: doc/BRIEF.md
# Cascadable Presettable Decade/Binary Digit Counter

This block is a 4-bit synchronous counter built to serve as one digit of a wider counter. Two elaboration-time parameters select its behaviour. `DECADE` picks BCD counting (0 to 9) or full binary counting (0 to 15). `ASYNC_CLR` picks an asynchronous or a synchronous clear. An active-low load captures a 4-bit word. Two active-high count enables are ANDed to let the count advance. The terminal-count output is gated only by the trickle enable, so stages can be chained without adding ripple delay.

Each cycle, a small decoder picks one of four operations:

- **OP_CLEAR**: clear is low. It has the highest priority.
- **OP_LOAD**: load is low and clear is high.
- **OP_COUNT**: clear and load are both high, and both enables are high.
- **OP_HOLD**: clear and load are both high, and either enable is low.

The register moves on these transitions:

- OP_CLEAR moves it to zero.
- OP_LOAD moves it to the data word.
- OP_COUNT moves it to the successor value.
- OP_HOLD keeps its value.

In decade mode the successor of a state with bit 0 and bit 3 both set is zero. Every other state increments by one. As a result, values 10 to 15 that were loaded return to the 0 to 9 sequence within two counting clocks.

To build a multi-digit counter, connect each stage's terminal count to the trickle enable of the next stage up. Drive all stages' parallel enables from one shared signal.

Top module: `sync_digit_counter`

## Requirements
- R1: With `DECADE`=1 and counting enabled, the count goes 0,1,...,9 and then returns to 0.
- R2: With `DECADE`=0 and counting enabled, the count goes 0,1,...,15 and then returns to 0.
- R3: With `ASYNC_CLR`=1, a low `clr_n` forces `count` to 0 without waiting for a clock edge, and keeps it there over every other input.
- R4: With `ASYNC_CLR`=0, a low `clr_n` sets `count` to 0 at the next rising edge, overriding load and count. `count` does not change before that edge.
- R5: When `clr_n` is high and `load_n` is low, `din` is captured at the rising edge, whatever the enables are.
- R6: The count advances by one step per rising edge only when `clr_n`, `load_n`, `en_par` and `en_trk` are all high.
- R7: When `clr_n` and `load_n` are high and either enable is low, `count` keeps its value.
- R8: `term` is high exactly when `en_trk` is high and `count` is at its maximum: 9 (binary 1001) in decade mode, 15 in binary mode. `en_par` has no effect on `term`.
- R9: In decade mode, a counting clock takes 10 to 11, 12 to 13 and 14 to 15, and takes 11, 13 and 15 to 0.
- R10: In decade mode, `term` is also high, with `en_trk` high, in states 11, 13 and 15.
- R11: Two stages chained as described count from 00 to 99 and wrap to 00 together, under either clear style.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (asynchronous or synchronous, chosen by parameter) |
| load_n | input | 1 | Active-low parallel load |
| din | input | 4 | Word captured on load |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates `term` |
| count | output | 4 | Present count |
| term | output | 1 | Terminal-count flag for cascading |

## Verification
The bench goes after the carry from 9 to the upper digit. A stage that decoded `term` from `en_par`, or registered it, would make the upper digit skip or lag a step. Out-of-range loads of 10, 12 and 14 are stepped through. A decoder that matched only the value 9 would let the counter run to 15 and desynchronise the upper stage. Clear is dropped between clock edges: an asynchronous stage that waited for the edge, or a synchronous stage that reacted at once, reads back the wrong value. Loads made while counting is enabled, and holds made with each enable low in turn, expose any priority error.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output cnt_op_e op
);
    // Priority: clear, then load, then count, then hold.
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_par && en_trk)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_next_value.sv
module cnt_next_value #(
    parameter bit DECADE = 1'b1,
    parameter int W      = 4
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    generate
        if (DECADE) begin : g_dec
            // States with bit 0 and the top bit set wrap to zero (9, 11, 13, 15).
            always_comb begin
                if (cur[0] && cur[W-1])
                    nxt = '0;
                else
                    nxt = cur + 1'b1;
            end
        end else begin : g_bin
            always_comb nxt = cur + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/cnt_term_decode.sv
module cnt_term_decode #(
    parameter bit DECADE = 1'b1,
    parameter int W      = 4
) (
    input  logic [W-1:0] cur,
    input  logic         en_trk,
    output logic         term
);
    generate
        if (DECADE) begin : g_dec
            // Same two bits as the wrap rule, so an upper stage steps with the wrap.
            always_comb term = en_trk && cur[0] && cur[W-1];
        end else begin : g_bin
            always_comb term = en_trk && (&cur);
        end
    endgenerate
endmodule

// File: rtl/sync_digit_counter.sv
module sync_digit_counter
    import cnt_pkg::*;
#(
    parameter bit DECADE    = 1'b1,
    parameter bit ASYNC_CLR = 1'b1,
    parameter int W         = CNT_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_par,
    input  logic         en_trk,
    output logic [W-1:0] count,
    output logic         term
);
    localparam logic [W-1:0] MAXV = DECADE ? W'(9) : {W{1'b1}};

    cnt_op_e      op;
    logic [W-1:0] succ;
    logic [W-1:0] count_d;
    logic [W-1:0] count_q;

    cnt_mode_sel u_mode (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    cnt_next_value #(.DECADE(DECADE), .W(W)) u_next (
        .cur (count_q),
        .nxt (succ)
    );

    cnt_term_decode #(.DECADE(DECADE), .W(W)) u_term (
        .cur    (count_q),
        .en_trk (en_trk),
        .term   (term)
    );

    // Next-state selection.
    always_comb begin
        unique case (op)
            OP_CLEAR: count_d = '0;
            OP_LOAD:  count_d = din;
            OP_COUNT: count_d = succ;
            OP_HOLD:  count_d = count_q;
        endcase
    end

    // State register: the clear style picks the register variant.
    generate
        if (ASYNC_CLR) begin : g_aclr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    count_q <= '0;
                else
                    count_q <= count_d;
            end

            assert_async_clear_R3: assert property (@(posedge clk)
                !clr_n |-> count == '0)
                else $error("R3: count nonzero during clear");
        end else begin : g_sclr
            always_ff @(posedge clk) begin
                count_q <= count_d;
            end

            assert_sync_clear_R4: assert property (@(posedge clk)
                !clr_n |=> count == '0)
                else $error("R4: clear not applied at edge");
        end
    endgenerate

    assign count = count_q;

    // Assertions next to the logic they guard.
    assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count == $past(din))
        else $error("R5: load value not captured");

    assert_step_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && count < MAXV) |=> count == W'($past(count) + 1'b1))
        else $error("R6: count did not advance by one");

    assert_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count))
        else $error("R7: count moved while an enable was low");

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && count == MAXV) |=> count == '0)
        else $error("R1: no wrap from maximum");

    assert_term_gate_R8: assert property (@(posedge clk) disable iff (!clr_n)
        term |-> en_trk)
        else $error("R8: term high with trickle enable low");

    assert_term_max_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (en_trk && count == MAXV) |-> term)
        else $error("R8: term missing at maximum");

    generate
        if (DECADE) begin : g_dec_chk
            assert_oor_step_R9: assert property (@(posedge clk) disable iff (!clr_n)
                (op == OP_COUNT && count > MAXV && !count[0]) |=> count == W'($past(count) + 1'b1))
                else $error("R9: even out-of-range state did not step");

            assert_oor_wrap_R9: assert property (@(posedge clk) disable iff (!clr_n)
                (op == OP_COUNT && count > MAXV && count[0]) |=> count == '0)
                else $error("R9: odd out-of-range state did not return to zero");
        end
    endgenerate
endmodule

// File: tb/sync_digit_counter_bench.sv
`timescale 1ns/1ps
module sync_digit_counter_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       clr_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [3:0] din_lo = '0, din_hi = '0;
    logic [3:0] lo_a, hi_a, lo_s, hi_s, bin_q;
    logic       tc_lo_a, tc_hi_a, tc_lo_s, tc_hi_s, tc_bin;

    int n_chk = 0;
    int n_bad = 0;

    // Chain A: decade digits with asynchronous clear.
    sync_digit_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b1)) u_sync_digit_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
        .en_par(en_par), .en_trk(en_trk), .count(lo_a), .term(tc_lo_a));
    sync_digit_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b1)) u_hi_a (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
        .en_par(en_par), .en_trk(tc_lo_a), .count(hi_a), .term(tc_hi_a));

    // Chain S: decade digits with synchronous clear.
    sync_digit_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_lo_s (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
        .en_par(en_par), .en_trk(en_trk), .count(lo_s), .term(tc_lo_s));
    sync_digit_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_hi_s (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
        .en_par(en_par), .en_trk(tc_lo_s), .count(hi_s), .term(tc_hi_s));

    // Binary-modulus stage.
    sync_digit_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b0)) u_bin (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
        .en_par(en_par), .en_trk(en_trk), .count(bin_q), .term(tc_bin));

    // Vector: {clr_n, load_n, en_par, en_trk, din_lo, din_hi, exp_lo, exp_hi}
    localparam int NV = 21;
    localparam logic [19:0] VEC [NV] = '{
        {4'b0111, 4'd0,  4'd0, 4'd0,  4'd0},
        {4'b1000, 4'd8,  4'd9, 4'd8,  4'd9},
        {4'b1111, 4'd0,  4'd0, 4'd9,  4'd9},
        {4'b1101, 4'd0,  4'd0, 4'd9,  4'd9},
        {4'b1110, 4'd0,  4'd0, 4'd9,  4'd9},
        {4'b1111, 4'd0,  4'd0, 4'd0,  4'd0},
        {4'b1011, 4'd7,  4'd3, 4'd7,  4'd3},
        {4'b1111, 4'd0,  4'd0, 4'd8,  4'd3},
        {4'b1111, 4'd0,  4'd0, 4'd9,  4'd3},
        {4'b1111, 4'd0,  4'd0, 4'd0,  4'd4},
        {4'b1011, 4'd10, 4'd5, 4'd10, 4'd5},
        {4'b1111, 4'd0,  4'd0, 4'd11, 4'd5},
        {4'b1111, 4'd0,  4'd0, 4'd0,  4'd6},
        {4'b1011, 4'd14, 4'd2, 4'd14, 4'd2},
        {4'b1111, 4'd0,  4'd0, 4'd15, 4'd2},
        {4'b1111, 4'd0,  4'd0, 4'd0,  4'd3},
        {4'b1011, 4'd12, 4'd0, 4'd12, 4'd0},
        {4'b1111, 4'd0,  4'd0, 4'd13, 4'd0},
        {4'b1111, 4'd0,  4'd0, 4'd0,  4'd1},
        {4'b0011, 4'd5,  4'd5, 4'd0,  4'd0},
        {4'b1111, 4'd0,  4'd0, 4'd1,  4'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        string tag;
        logic [3:0] prev_lo;
        // Reset state.
        #1 clr_n = 1'b0;
        @(negedge clk);
        chk("R3", lo_a, 0);
        chk("R4", lo_s, 0);
        prev_lo = 4'd0;

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            {clr_n, load_n, en_par, en_trk} = VEC[v][19:16];
            din_lo = VEC[v][15:12];
            din_hi = VEC[v][11:8];
            if (!clr_n) tag = "R4";
            else if (!load_n) tag = "R5";
            else if (prev_lo > 4'd9) tag = "R9";
            else if (en_par && en_trk) tag = (prev_lo == 4'd9) ? "R11" : "R6";
            else tag = "R7";
            @(negedge clk);
            chk(tag, lo_a, int'(VEC[v][7:4]));
            chk(tag, hi_a, int'(VEC[v][3:0]));
            chk(tag, lo_s, int'(VEC[v][7:4]));
            chk(tag, hi_s, int'(VEC[v][3:0]));
            chk((VEC[v][7:4] > 4'd9) ? "R10" : "R8", tc_lo_a,
                int'(en_trk && VEC[v][4] && VEC[v][7]));
            prev_lo = VEC[v][7:4];
        end

        // Clear dropped between edges: both chains hold 1 here.
        en_par = 1'b0;
        clr_n = 1'b0;
        #1;
        chk("R3", lo_a, 0);
        chk("R4", lo_s, 1);
        @(negedge clk);
        chk("R4", lo_s, 0);

        // Two-digit run past 99.
        clr_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
        for (int i = 1; i <= 105; i++) begin
            @(negedge clk);
            chk("R1", lo_a, i % 10);
            chk("R11", int'(hi_a) * 10 + int'(lo_a), i % 100);
            chk("R11", int'(hi_s) * 10 + int'(lo_s), i % 100);
        end

        // Binary stage.
        load_n = 1'b0; din_lo = 4'd9;
        @(negedge clk);
        chk("R8", tc_bin, 0);
        din_lo = 4'd14;
        @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
        chk("R2", bin_q, 15);
        chk("R8", tc_bin, 1);
        en_par = 1'b0;
        #1 chk("R8", tc_bin, 1);
        en_trk = 1'b0;
        #1 chk("R8", tc_bin, 0);
        @(negedge clk);
        chk("R7", bin_q, 15);
        en_par = 1'b1; en_trk = 1'b1;
        @(negedge clk);
        chk("R2", bin_q, 0);

        summary();
    end
endmodule